// File: doc/BRIEF.md
# Interrupt Distributor Register Block

This block sits between the interrupt sources of a small multi-core cluster and the per-core interrupt request lines. Software programs it through a simple word-addressed register port: it turns the whole distributor on and off, enables and disables each source, gives each source a priority, chooses level or edge detection for shared sources, routes shared sources to cores, and raises software-generated interrupts aimed at a list of cores.

The ID space holds 64 IDs by default. IDs 0 to 15 are software-generated and tracked separately for each core. IDs 16 to 31 are private: core n owns its own sixteen inputs for these IDs. IDs 32 and up are shared sources with a routing field. For every core the block picks the enabled, pending source with the best priority. It drives a request line for that core, along with the winning ID and its priority.

Register writes take effect at the next clock edge. The pending state is registered one edge after the input changes. The per-core outputs are registered one edge after that.

Top module: `irq_distributor`

## Requirements
- R1: After reset the distributor is off, every enable, priority, target, trigger mode and pending bit is zero, and all core request lines are low.
- R2: The control word at byte address 0x000 holds the global enable in bit 0, and the other bits read as zero. While bit 0 is clear, no core request line is raised.
- R3: Writing a 1 to bit (ID mod 32) of the word at 0x100 + 4*(ID/32) enables that ID. Writing a 1 to the same bit at 0x180 + 4*(ID/32) disables it. Zero bits leave the enable unchanged. Both addresses read back the current enable bits.
- R4: A source that is disabled keeps its pending state. If that state is still present when the source is enabled again, it produces a request.
- R5: The priority of an ID sits in byte (ID mod 4) of the word at 0x400 + 4*(ID/4). Only bits 7:3 are stored, and bits 2:0 always read as zero. A lower value means a more urgent source.
- R6: The trigger field of an ID is bits 2*(ID mod 16)+1 and 2*(ID mod 16) of the word at 0xC00 + 4*(ID/16). Software IDs always read 2'b10 and private IDs always read 2'b01, and writes to both are ignored. For shared IDs the low bit always reads 1. The high bit is writable and selects rising-edge (1) or active-high level (0).
- R7: A shared ID has a target byte at byte (ID mod 4) of the word at 0x800 + 4*(ID/4). Bit n of that byte sends the ID to core n. Only the bits for existing cores are stored, and the other bits read as zero. The target bytes of IDs below 32 read as zero.
- R8: A write to 0x F00 with core list bits 23:16 and ID bits 3:0 sets that software ID pending for every core whose bit is 1 in the list.
- R9: For each core, the request presents the enabled, pending ID with the lowest priority value. Ties go to the lower ID. The ID is in bits 6c+5:6c of core_id and the priority byte is in bits 8c+7:8c of core_prio. If no ID is eligible, the request line is low.
- R10: A level-mode shared source is pending exactly while its input is high. An edge-mode shared source becomes pending on a rising edge and stays pending until it is cleared.
- R11: Writing a 1 to bit (ID mod 32) of the word at 0x280 + 4*(ID/32) clears that ID's latched pending state. For a software ID this clears it on every core. The write has no effect on a level source whose input is high.
- R12: Private input 16c+k is the level-sensitive source for ID 16+k on core c only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ppi_in | input | NUM_CORES*16 | Private inputs, sixteen per core |
| spi_in | input | SPI_COUNT | Shared source inputs, bit j is ID 32+j |
| core_req | output | NUM_CORES | Per-core request line |
| core_id | output | NUM_CORES*IDW | Winning ID per core |
| core_prio | output | NUM_CORES*8 | Winning priority byte per core |

## Verification
The hardest case to reach is a source whose pending state must survive while it is masked. An edge-mode shared input is pulsed while its enable is clear, and nothing may appear on the request line. Only a later set-enable write may bring the request out, and it must then drop after a clear-pending write. The software interrupts are also aimed at a single core, then at both, then cleared for all. This shows that pending state is kept per core and that the clear reaches every copy.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    // word indices (byte address / 4) of each register region
    localparam int W_CTRL  = 'h000;
    localparam int W_ENSET = 'h040;
    localparam int W_ENCLR = 'h060;
    localparam int W_PCLR  = 'h0A0;
    localparam int W_PRIO  = 'h100;
    localparam int W_TGT   = 'h200;
    localparam int W_CFG   = 'h300;
    localparam int W_SGI   = 'h3C0;

    localparam int PRIO_BITS = 5;
    localparam int SGI_IDS   = 16;
    localparam int PPI_IDS   = 16;
    localparam int SPI_BASE  = SGI_IDS + PPI_IDS;

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'b01,
        TRIG_SOFT  = 2'b10,
        TRIG_EDGE  = 2'b11
    } trig_e;

    typedef struct packed {
        logic [7:0] cores;
        logic [3:0] id;
    } sgi_cmd_t;

    function automatic sgi_cmd_t decode_sgi(logic [31:0] w);
        sgi_cmd_t c;
        c.cores = w[23:16];
        c.id    = w[3:0];
        return c;
    endfunction

    function automatic logic [7:0] prio_byte(logic [PRIO_BITS-1:0] p);
        return {p, 3'b000};
    endfunction

endpackage

// File: rtl/irqd_regs.sv
module irqd_regs
    import irqd_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int SPI_COUNT = 32,
    localparam int NUM_IRQ  = SPI_BASE + SPI_COUNT
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    wr,
    input  logic [11:0]                             addr,
    input  logic [31:0]                             wdata,
    output logic [31:0]                             rdata,
    output logic                                    dist_en,
    output logic [NUM_IRQ-1:0]                      enable,
    output logic [NUM_IRQ-1:0][PRIO_BITS-1:0]       prio,
    output logic [SPI_COUNT-1:0][NUM_CORES-1:0]     target,
    output logic [SPI_COUNT-1:0]                    edge_sel,
    output logic [NUM_IRQ-1:0]                      pend_clr,
    output logic [NUM_CORES-1:0][SGI_IDS-1:0]       sgi_set
);

    logic [31:0] word;
    sgi_cmd_t    cmd;

    assign word = {22'd0, addr[11:2]};
    assign cmd  = decode_sgi(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            dist_en  <= 1'b0;
            enable   <= '0;
            prio     <= '0;
            target   <= '0;
            edge_sel <= '0;
        end else if (wr) begin
            if (word == W_CTRL) dist_en <= wdata[0];
            for (int i = 0; i < NUM_IRQ; i++) begin
                if (word == W_ENSET + i/32 && wdata[i%32]) enable[i] <= 1'b1;
                if (word == W_ENCLR + i/32 && wdata[i%32]) enable[i] <= 1'b0;
                if (word == W_PRIO + i/4) prio[i] <= wdata[(i%4)*8+3 +: PRIO_BITS];
            end
            for (int j = 0; j < SPI_COUNT; j++) begin
                if (word == W_TGT + (SPI_BASE + j)/4)
                    target[j] <= wdata[(j%4)*8 +: NUM_CORES];
                if (word == W_CFG + (SPI_BASE + j)/16)
                    edge_sel[j] <= wdata[((SPI_BASE + j)%16)*2 + 1];
            end
        end
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_pclr
        assign pend_clr[i] = wr && (word == W_PCLR + i/32) && wdata[i%32];
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        for (genvar k = 0; k < SGI_IDS; k++) begin : g_sgi
            assign sgi_set[c][k] = wr && (word == W_SGI) && cmd.cores[c] && (cmd.id == 4'(k));
        end
    end

    always_comb begin
        rdata = '0;
        if (word == W_CTRL) rdata[0] = dist_en;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (word == W_ENSET + i/32 || word == W_ENCLR + i/32) rdata[i%32] = enable[i];
            if (word == W_PRIO + i/4) rdata[(i%4)*8 +: 8] = prio_byte(prio[i]);
        end
        for (int i = 0; i < SPI_BASE; i++) begin
            if (word == W_CFG + i/16)
                rdata[(i%16)*2 +: 2] = (i < SGI_IDS) ? TRIG_SOFT : TRIG_LEVEL;
        end
        for (int j = 0; j < SPI_COUNT; j++) begin
            if (word == W_CFG + (SPI_BASE + j)/16)
                rdata[((SPI_BASE + j)%16)*2 +: 2] = edge_sel[j] ? TRIG_EDGE : TRIG_LEVEL;
            if (word == W_TGT + (SPI_BASE + j)/4)
                rdata[(j%4)*8 +: 8] = 8'(target[j]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && word >= W_PRIO && word < W_PRIO + NUM_IRQ/4)
            assert_prio_low_zero_R5: assert ((rdata & 32'h0707_0707) == 32'd0)
                else $error("priority low bits nonzero");
        if (!rst && word == W_CFG)
            assert_soft_trig_fixed_R6: assert (rdata == 32'hAAAA_AAAA)
                else $error("software trigger field not fixed");
    end

endmodule

// File: rtl/irqd_pending.sv
module irqd_pending
    import irqd_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int SPI_COUNT = 32,
    localparam int NUM_IRQ  = SPI_BASE + SPI_COUNT
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [NUM_CORES*PPI_IDS-1:0]         ppi_in,
    input  logic [SPI_COUNT-1:0]                 spi_in,
    input  logic [SPI_COUNT-1:0]                 edge_sel,
    input  logic [NUM_IRQ-1:0]                   pend_clr,
    input  logic [NUM_CORES-1:0][SGI_IDS-1:0]    sgi_set,
    output logic [NUM_CORES-1:0][SGI_IDS-1:0]    sgi_pend,
    output logic [NUM_CORES-1:0][PPI_IDS-1:0]    ppi_pend,
    output logic [SPI_COUNT-1:0]                 spi_pend
);

    logic [SPI_COUNT-1:0] spi_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sgi_pend <= '0;
            ppi_pend <= '0;
            spi_pend <= '0;
            spi_prev <= '0;
        end else begin
            spi_prev <= spi_in;
            for (int c = 0; c < NUM_CORES; c++) begin
                sgi_pend[c] <= (sgi_pend[c] & ~pend_clr[SGI_IDS-1:0]) | sgi_set[c];
                ppi_pend[c] <= ppi_in[c*PPI_IDS +: PPI_IDS];
            end
            for (int j = 0; j < SPI_COUNT; j++) begin
                if (edge_sel[j])
                    spi_pend[j] <= (spi_pend[j] & ~pend_clr[SPI_BASE + j]) | (spi_in[j] & ~spi_prev[j]);
                else
                    spi_pend[j] <= spi_in[j];
            end
        end
    end

    for (genvar j = 0; j < SPI_COUNT; j++) begin : g_spi_chk
        assert_edge_hold_R10: assert property (@(posedge clk) disable iff (rst)
            (edge_sel[j] && spi_pend[j] && !pend_clr[SPI_BASE + j]) |=> spi_pend[j]);
        assert_level_follow_R10: assert property (@(posedge clk) disable iff (rst)
            !edge_sel[j] |=> (spi_pend[j] == $past(spi_in[j])));
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_sgi_chk
        for (genvar k = 0; k < SGI_IDS; k++) begin : g_id
            assert_soft_clear_R11: assert property (@(posedge clk) disable iff (rst)
                (pend_clr[k] && !sgi_set[c][k]) |=> !sgi_pend[c][k]);
        end
    end

endmodule

// File: rtl/irqd_select.sv
module irqd_select
    import irqd_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    localparam int IDW    = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0]                 elig,
    input  logic [NUM_IRQ-1:0][PRIO_BITS-1:0]  prio,
    output logic                               hit,
    output logic [IDW-1:0]                     id,
    output logic [PRIO_BITS-1:0]               best
);

    always_comb begin
        hit  = 1'b0;
        id   = '0;
        best = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            // strict compare keeps the lower ID on a tie
            if (elig[i] && (!hit || prio[i] < best)) begin
                hit  = 1'b1;
                id   = IDW'(i);
                best = prio[i];
            end
        end
    end

endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
    import irqd_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int SPI_COUNT = 32,
    localparam int NUM_IRQ  = SPI_BASE + SPI_COUNT,
    localparam int IDW      = $clog2(NUM_IRQ)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          reg_wr,
    input  logic [11:0]                   reg_addr,
    input  logic [31:0]                   reg_wdata,
    output logic [31:0]                   reg_rdata,
    input  logic [NUM_CORES*PPI_IDS-1:0]  ppi_in,
    input  logic [SPI_COUNT-1:0]          spi_in,
    output logic [NUM_CORES-1:0]          core_req,
    output logic [NUM_CORES*IDW-1:0]      core_id,
    output logic [NUM_CORES*8-1:0]        core_prio
);

    logic                                 dist_en;
    logic [NUM_IRQ-1:0]                   enable;
    logic [NUM_IRQ-1:0][PRIO_BITS-1:0]    prio;
    logic [SPI_COUNT-1:0][NUM_CORES-1:0]  target;
    logic [SPI_COUNT-1:0]                 edge_sel;
    logic [NUM_IRQ-1:0]                   pend_clr;
    logic [NUM_CORES-1:0][SGI_IDS-1:0]    sgi_set;
    logic [NUM_CORES-1:0][SGI_IDS-1:0]    sgi_pend;
    logic [NUM_CORES-1:0][PPI_IDS-1:0]    ppi_pend;
    logic [SPI_COUNT-1:0]                 spi_pend;
    logic [NUM_CORES-1:0][NUM_IRQ-1:0]    elig;

    irqd_regs #(.NUM_CORES(NUM_CORES), .SPI_COUNT(SPI_COUNT)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .dist_en(dist_en), .enable(enable), .prio(prio),
        .target(target), .edge_sel(edge_sel), .pend_clr(pend_clr), .sgi_set(sgi_set)
    );

    irqd_pending #(.NUM_CORES(NUM_CORES), .SPI_COUNT(SPI_COUNT)) u_pend (
        .clk(clk), .rst(rst), .ppi_in(ppi_in), .spi_in(spi_in), .edge_sel(edge_sel),
        .pend_clr(pend_clr), .sgi_set(sgi_set), .sgi_pend(sgi_pend),
        .ppi_pend(ppi_pend), .spi_pend(spi_pend)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic                 sel_hit;
        logic [IDW-1:0]       sel_id;
        logic [PRIO_BITS-1:0] sel_prio;

        for (genvar i = 0; i < NUM_IRQ; i++) begin : g_id
            logic raw;
            if (i < SGI_IDS) begin : g_soft
                assign raw = sgi_pend[c][i];
            end else if (i < SPI_BASE) begin : g_priv
                assign raw = ppi_pend[c][i - SGI_IDS];
            end else begin : g_shared
                assign raw = spi_pend[i - SPI_BASE] && target[i - SPI_BASE][c];
            end
            assign elig[c][i] = raw && enable[i] && dist_en;
        end

        irqd_select #(.NUM_IRQ(NUM_IRQ)) u_sel (
            .elig(elig[c]), .prio(prio), .hit(sel_hit), .id(sel_id), .best(sel_prio)
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                core_req[c]            <= 1'b0;
                core_id[c*IDW +: IDW]  <= '0;
                core_prio[c*8 +: 8]    <= '0;
            end else begin
                core_req[c]            <= sel_hit;
                core_id[c*IDW +: IDW]  <= sel_id;
                core_prio[c*8 +: 8]    <= sel_hit ? prio_byte(sel_prio) : 8'd0;
            end
        end

        assert_idle_when_none_R9: assert property (@(posedge clk) disable iff (rst)
            (elig[c] == '0) |=> !core_req[c]);
        assert_out_prio_format_R5: assert property (@(posedge clk) disable iff (rst)
            core_req[c] |-> (core_prio[c*8 +: 3] == 3'd0));
    end

    assert_global_gate_R2: assert property (@(posedge clk) disable iff (rst)
        !dist_en |=> (core_req == '0));

endmodule

// File: tb/irq_distributor_test.sv
module irq_distributor_test;

    localparam int NC  = 2;
    localparam int NS  = 32;
    localparam int IDW = 6;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            reg_wr = 1'b0;
    logic [11:0]     reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NC*16-1:0] ppi_in = '0;
    logic [NS-1:0]   spi_in = '0;
    logic [NC-1:0]   core_req;
    logic [NC*IDW-1:0] core_id;
    logic [NC*8-1:0] core_prio;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    irq_distributor #(.NUM_CORES(NC), .SPI_COUNT(NS)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ppi_in(ppi_in),
        .spi_in(spi_in), .core_req(core_req), .core_id(core_id), .core_prio(core_prio)
    );

    typedef struct packed {
        logic [11:0] wa;
        logic [31:0] wd;
        logic [11:0] ra;
        logic [31:0] ex;
        logic [7:0]  rq;
    } vec_t;

    localparam vec_t VT [14] = '{
        '{12'h100, 32'h0000_0005, 12'h100, 32'h0000_0005, 8'd3},  // R3 set
        '{12'h180, 32'h0000_0001, 12'h100, 32'h0000_0004, 8'd3},  // R3 clear
        '{12'h104, 32'h8000_0000, 12'h184, 32'h8000_0000, 8'd3},  // R3 second bank
        '{12'h104, 32'h0000_0000, 12'h104, 32'h8000_0000, 8'd3},  // R3 zero bits
        '{12'h404, 32'hFFFF_FFFF, 12'h404, 32'hF8F8_F8F8, 8'd5},  // R5
        '{12'h400, 32'h1234_5678, 12'h400, 32'h1030_5078, 8'd5},  // R5
        '{12'hC00, 32'h0000_0000, 12'hC00, 32'hAAAA_AAAA, 8'd6},  // R6 soft
        '{12'hC04, 32'hFFFF_FFFF, 12'hC04, 32'h5555_5555, 8'd6},  // R6 private
        '{12'hC08, 32'hFFFF_FFFF, 12'hC08, 32'hFFFF_FFFF, 8'd6},  // R6 shared edge
        '{12'hC08, 32'h0000_0000, 12'hC08, 32'h5555_5555, 8'd6},  // R6 shared level
        '{12'h820, 32'hFFFF_FF03, 12'h820, 32'h0303_0303, 8'd7},  // R7 core bits
        '{12'h800, 32'hFFFF_FFFF, 12'h800, 32'h0000_0000, 8'd7},  // R7 low IDs
        '{12'h820, 32'h0000_0201, 12'h820, 32'h0000_0201, 8'd7},  // R7
        '{12'h000, 32'h0000_0003, 12'h000, 32'h0000_0001, 8'd2}   // R2 ctrl
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
    endtask

    function automatic logic [31:0] cid(input int c);
        return 32'(core_id[c*IDW +: IDW]);
    endfunction

    function automatic logic [31:0] cpr(input int c);
        return 32'(core_prio[c*8 +: 8]);
    endfunction

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // register table
        for (int k = 0; k < 14; k++) begin
            wr(VT[k].wa, VT[k].wd);
            rd(VT[k].ra, d);
            check($sformatf("R%0d vec%0d", VT[k].rq, k), d, VT[k].ex);
        end

        // R1 reset state
        do_reset();
        settle();
        check("R1 req", 32'(core_req), 32'd0);
        rd(12'h000, d); check("R1 ctrl", d, 32'd0);
        rd(12'h100, d); check("R1 enable", d, 32'd0);
        rd(12'h400, d); check("R1 prio", d, 32'd0);
        rd(12'h820, d); check("R1 target", d, 32'd0);

        // R2 global gate, R7 routing: ID 40 level to core 0
        wr(12'h828, 32'h0000_0001);
        wr(12'h104, 32'h0000_0100);
        spi_in[8] = 1'b1;
        settle();
        check("R2 off", 32'(core_req), 32'd0);
        wr(12'h000, 32'h1);
        settle();
        check("R7 route", 32'(core_req), 32'b01);
        check("R9 id40", cid(0), 32'd40);

        // R9 priority and tie
        wr(12'h428, 32'h0000_0080);
        wr(12'h42C, 32'h0000_4000);
        wr(12'h82C, 32'h0000_0100);
        wr(12'h104, 32'h0000_2000);
        spi_in[13] = 1'b1;
        settle();
        check("R9 best id", cid(0), 32'd45);
        check("R9 best prio", cpr(0), 32'h40);
        wr(12'h42C, 32'h0000_8000);
        settle();
        check("R9 tie", cid(0), 32'd40);

        // R4 / R10 edge latch while disabled
        wr(12'h184, 32'hFFFF_FFFF);
        spi_in = '0;
        wr(12'hC08, 32'h0002_0000);
        @(negedge clk); spi_in[8] = 1'b1;
        @(negedge clk); spi_in[8] = 1'b0;
        settle();
        check("R4 masked", 32'(core_req), 32'd0);
        wr(12'h104, 32'h0000_0100);
        settle();
        check("R4 reenable", 32'(core_req), 32'b01);
        check("R10 latch id", cid(0), 32'd40);
        wr(12'h284, 32'h0000_0100);
        settle();
        check("R11 edge clear", 32'(core_req), 32'd0);

        // R10 level follow, R11 no effect on level
        wr(12'h104, 32'h0000_2000);
        spi_in[13] = 1'b1;
        settle();
        check("R10 level high", cid(0) | {31'd0, !core_req[0]}, 32'd45);
        spi_in[13] = 1'b0;
        settle();
        check("R10 level low", 32'(core_req), 32'd0);
        spi_in[13] = 1'b1;
        wr(12'h284, 32'h0000_2000);
        settle();
        check("R11 level kept", 32'(core_req), 32'b01);

        // R8 software interrupts
        wr(12'h184, 32'hFFFF_FFFF);
        spi_in = '0;
        wr(12'h400, 32'h2000_0000);
        wr(12'h404, 32'h0000_1000);
        wr(12'h100, 32'h0000_0028);
        wr(12'hF00, 32'h0002_0003);
        settle();
        check("R8 one core", 32'(core_req), 32'b10);
        check("R8 id3", cid(1), 32'd3);
        check("R8 prio", cpr(1), 32'h20);
        wr(12'hF00, 32'h0003_0005);
        settle();
        check("R8 both", 32'(core_req), 32'b11);
        check("R9 core1 id5", cid(1), 32'd5);
        wr(12'h280, 32'h0000_0020);
        settle();
        check("R11 soft clear", 32'(core_req), 32'b10);
        check("R11 core1 back", cid(1), 32'd3);

        // R12 private inputs
        wr(12'h100, 32'h0010_0000);
        ppi_in = 32'h0010_0000;
        settle();
        check("R12 core1 only", 32'(core_req), 32'b10);
        check("R12 id20", cid(1), 32'd20);
        ppi_in = 32'h0000_0010;
        settle();
        check("R12 core0", 32'(core_req), 32'b11);
        check("R12 core0 id", cid(0), 32'd20);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule